// File: doc/BRIEF.md
# Raster-Timed Interrupt Status and Enable Register

This block collects the interrupt requests of a small display and tape chip into one byte that the CPU reads at a single bus address. Writing that same address loads an enable mask. A single active-low interrupt line goes to the CPU. It is asserted whenever a request is active and its enable bit is set.

Two of the requests come from a built-in raster counter. The frame is 312 scanlines long and each scanline is 128 ticks of the 2 MHz clock enable. One request fires when the scanline that ends the visible picture finishes, and another fires when scanline 100 finishes. Both stay set until software writes a 1 to the matching bit of a separate clear register. Two tape requests follow their own set and clear strobes: a byte has arrived, and the transmitter wants a byte. A power-up flag is set by reset and is cleared by the first status read.

Status byte layout: bit 0 is the master request, bit 1 is power-up, bit 2 is end-of-picture, bit 3 is the line-100 timer, bit 4 is receive-full, bit 5 is transmit-empty, bit 6 reads 0, and bit 7 reads 1. The enable mask and the clear register use the same bit positions.

Top module: `irq_ctl_top`

## Requirements
- R1: `stat_data` presents the status byte with the bit layout given above at all times. A source bit reads 1 while that source is requesting, whatever its enable bit.
- R2: Status bit 7 always reads 1 and bit 6 always reads 0.
- R3: A `ctl_wr` strobe loads `ctl_data[5:2]` into the enable mask. Bits 0, 1, 6 and 7 of the written value have no effect: they cannot force the master bit or the power-up bit.
- R4: Status bit 0 is 1 exactly when some source has both its request and its enable bit set. `irq_n` is the inverse of bit 0.
- R5: The power-up bit is 1 after reset. It reads 1 during the first `stat_rd` strobe and 0 from the next cycle on.
- R6: The raster position advances only on clock cycles with `tick_en` high. A frame spans 312 lines of 128 ticks, after which the position returns to line 0, tick 0.
- R7: Counting ticks from reset, the end-of-picture bit becomes 1 after tick number 32768 (the end of line 255), and not before.
- R8: The line-100 timer bit becomes 1 after tick 12928 (the end of line 100), and it fires again one frame later, at tick 52864.
- R9: `rx_byte` sets receive-full and `tape_rd` clears it. If both come in the same cycle, the bit is set.
- R10: Transmit-empty is set by `tx_need` or by a rising edge of `tx_mode`. Only `tape_wr` clears it; `tape_rd` leaves it alone.
- R11: A `clr_wr` strobe with `clr_data` bit 2 clears end-of-picture, and with bit 3 clears the line-100 timer. The other clear bits have no effect. A raster event in the same cycle as its clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 2 MHz raster tick enable |
| stat_rd | input | 1 | Read strobe of the status/enable address |
| ctl_wr | input | 1 | Write strobe of the status/enable address |
| ctl_data | input | 8 | Enable mask write data |
| clr_wr | input | 1 | Write strobe of the clear register |
| clr_data | input | 8 | Clear register write data |
| tape_rd | input | 1 | Tape data register read strobe |
| tape_wr | input | 1 | Tape data register write strobe |
| rx_byte | input | 1 | Tape receiver has a complete byte |
| tx_need | input | 1 | Tape transmitter wants a byte |
| tx_mode | input | 1 | Tape write mode level |
| stat_data | output | 8 | Status byte |
| irq_n | output | 1 | Active-low interrupt to the CPU |

## Verification
The master bit and `irq_n` are swept over all 16 enable masks against all four combinations of the two tape requests. This separates a mask that is applied per bit from one that is applied as a whole, and it catches any enable bit that is wired to the wrong source. The raster requests are sampled on the cycle before and the cycle after their predicted tick. A tick-enable gap is included, so an off-by-one line or cycle count, or a counter that runs without ticks, shows up as a one-cycle shift. The collision patterns (a set strobe together with its clear strobe, and the line-100 event together with its clear write) tell set-priority apart from clear-priority. Writes of the ignored bits and reads of the tape register tell which strobes may touch which bits.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int STAT_W    = 8;
  localparam int NSRC      = 4;
  localparam int BIT_MAST  = 0;
  localparam int BIT_PWR   = 1;
  localparam int SRC_LSB   = 2;
  localparam int SRC_DEND  = 0;
  localparam int SRC_TMR   = 1;
  localparam int SRC_RXF   = 2;
  localparam int SRC_TXE   = 3;
  localparam int BIT_SPARE = 6;
  localparam int BIT_ONE   = 7;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_raster.sv
module irq_raster #(
  parameter int LINES      = 312,
  parameter int LINE_TICKS = 128,
  parameter int DEND_LINE  = 255,
  parameter int TMR_LINE   = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic dend_evt,
  output logic tmr_evt
);
  localparam int CYC_W    = $clog2(LINE_TICKS);
  localparam int LINE_W   = $clog2(LINES);
  localparam logic [CYC_W-1:0]  CYC_MAX  = CYC_W'(LINE_TICKS - 1);
  localparam logic [LINE_W-1:0] LINE_MAX = LINE_W'(LINES - 1);
  localparam int NEVT = 2;
  localparam logic [LINE_W-1:0] EVT_LINE [NEVT] = '{LINE_W'(DEND_LINE), LINE_W'(TMR_LINE)};

  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              line_end;
  logic [NEVT-1:0]   evt;

  assign line_end = tick_en && (cyc_q == CYC_MAX);

  always_comb begin
    cyc_d  = cyc_q;
    line_d = line_q;
    if (tick_en) begin
      if (cyc_q == CYC_MAX) begin
        cyc_d  = '0;
        line_d = (line_q == LINE_MAX) ? '0 : line_q + 1'b1;
      end else begin
        cyc_d = cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      line_q <= '0;
    end else if (tick_en) begin
      cyc_q  <= cyc_d;
      line_q <= line_d;
    end
  end

  for (genvar g = 0; g < NEVT; g++) begin : g_evt
    assign evt[g] = line_end && (line_q == EVT_LINE[g]);
  end

  assign dend_evt = evt[0];
  assign tmr_evt  = evt[1];

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && line_q == LINE_MAX) |=> (line_q == '0 && cyc_q == '0)); // R6
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(cyc_q) && $stable(line_q))); // R6
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dend_evt && tmr_evt)); // R7
endmodule

// File: rtl/irq_req_cell.sv
module irq_req_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic req_o
);
  logic req_d, req_q;

  always_comb begin
    req_d = req_q;
    if (clr_i) req_d = 1'b0;
    if (set_i) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               req_q <= 1'b0;
    else if (set_i || clr_i)  req_q <= req_d;
  end

  assign req_o = req_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> req_o); // R11
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !req_o); // R9
endmodule

// File: rtl/irq_sources.sv
module irq_sources
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dend_evt,
  input  logic     tmr_evt,
  input  logic     clr_wr,
  input  logic [1:0] clr_bits,
  input  logic     tape_rd,
  input  logic     tape_wr,
  input  logic     rx_byte,
  input  logic     tx_need,
  input  logic     tx_mode,
  output src_vec_t req
);
  logic     mode_q;
  logic     mode_rise;
  src_vec_t set_v, clr_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= tx_mode;
  end

  assign mode_rise = tx_mode && !mode_q;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[SRC_DEND] = dend_evt;
    set_v[SRC_TMR]  = tmr_evt;
    set_v[SRC_RXF]  = rx_byte;
    set_v[SRC_TXE]  = tx_need || mode_rise;
    clr_v[SRC_DEND] = clr_wr && clr_bits[0];
    clr_v[SRC_TMR]  = clr_wr && clr_bits[1];
    clr_v[SRC_RXF]  = tape_rd;
    clr_v[SRC_TXE]  = tape_wr;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_cell
    irq_req_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .req_o (req[g])
    );
  end

  AST_TXE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req[SRC_TXE] && !tape_wr) |=> req[SRC_TXE]); // R10
  AST_RXF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (tape_rd && !rx_byte) |=> !req[SRC_RXF]); // R9
  AST_TMR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bits[1] && !tmr_evt) |=> !req[SRC_TMR]); // R11
  AST_DEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req[SRC_DEND] && !(clr_wr && clr_bits[0])) |=> req[SRC_DEND]); // R7
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_pkg::*;
#(
  parameter int LINES      = 312,
  parameter int LINE_TICKS = 128,
  parameter int DEND_LINE  = 255,
  parameter int TMR_LINE   = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       stat_rd,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_data,
  input  logic       clr_wr,
  input  logic [7:0] clr_data,
  input  logic       tape_rd,
  input  logic       tape_wr,
  input  logic       rx_byte,
  input  logic       tx_need,
  input  logic       tx_mode,
  output logic [7:0] stat_data,
  output logic       irq_n
);
  localparam int SRC_MSB = SRC_LSB + NSRC - 1;

  logic     rst_i_n;
  logic     dend_evt, tmr_evt;
  src_vec_t req;
  src_vec_t en_q, en_d;
  logic     pwr_q, pwr_d;
  logic     master;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  irq_raster #(
    .LINES      (LINES),
    .LINE_TICKS (LINE_TICKS),
    .DEND_LINE  (DEND_LINE),
    .TMR_LINE   (TMR_LINE)
  ) u_raster (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick_en  (tick_en),
    .dend_evt (dend_evt),
    .tmr_evt  (tmr_evt)
  );

  irq_sources u_src (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .dend_evt (dend_evt),
    .tmr_evt  (tmr_evt),
    .clr_wr   (clr_wr),
    .clr_bits (clr_data[SRC_LSB+SRC_TMR:SRC_LSB+SRC_DEND]),
    .tape_rd  (tape_rd),
    .tape_wr  (tape_wr),
    .rx_byte  (rx_byte),
    .tx_need  (tx_need),
    .tx_mode  (tx_mode),
    .req      (req)
  );

  always_comb begin
    en_d  = ctl_wr ? ctl_data[SRC_MSB:SRC_LSB] : en_q;
    pwr_d = stat_rd ? 1'b0 : pwr_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      en_q  <= '0;
      pwr_q <= 1'b1;
    end else begin
      if (ctl_wr)  en_q  <= en_d;
      if (stat_rd) pwr_q <= pwr_d;
    end
  end

  assign master = |(req & en_q);

  always_comb begin
    stat_data                  = '0;
    stat_data[BIT_MAST]        = master;
    stat_data[BIT_PWR]         = pwr_q;
    stat_data[SRC_MSB:SRC_LSB] = req;
    stat_data[BIT_SPARE]       = 1'b0;
    stat_data[BIT_ONE]         = 1'b1;
  end

  assign irq_n = ~master;

  AST_TOP_ONE: assert property (@(posedge clk) disable iff (!rst_i_n)
    stat_data[BIT_ONE] && !stat_data[BIT_SPARE]); // R2
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ctl_wr && ctl_data[SRC_MSB:SRC_LSB] == '0) |=> irq_n); // R4
  AST_PWR_GONE: assert property (@(posedge clk) disable iff (!rst_i_n)
    stat_rd |=> !stat_data[BIT_PWR]); // R5
  AST_PWR_STAYS: assert property (@(posedge clk) disable iff (!rst_i_n)
    !stat_data[BIT_PWR] |=> !stat_data[BIT_PWR]); // R3
  AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_i_n)
    !irq_n |-> (stat_data[SRC_MSB:SRC_LSB] != '0)); // R4
endmodule

// File: tb/irq_ctl_top_tb.sv
module irq_ctl_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, stat_rd, ctl_wr, clr_wr, tape_rd, tape_wr;
  logic       rx_byte, tx_need, tx_mode;
  logic [7:0] ctl_data, clr_data, stat_data;
  logic       irq_n;
  int         total = 0;
  int         bad = 0;
  int         tk = 0;
  int         cyc = 0;

  always #2 clk = ~clk;

  irq_ctl_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .stat_rd(stat_rd),
    .ctl_wr(ctl_wr), .ctl_data(ctl_data), .clr_wr(clr_wr), .clr_data(clr_data),
    .tape_rd(tape_rd), .tape_wr(tape_wr), .rx_byte(rx_byte), .tx_need(tx_need),
    .tx_mode(tx_mode), .stat_data(stat_data), .irq_n(irq_n)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tick_en) tk <= tk + 1;
  end

  function automatic logic [7:0] exp_stat(input bit pwr, input bit dend, input bit tmr,
                                          input bit rxf, input bit txe, input logic [3:0] en);
    logic [3:0] r;
    r = {txe, rxf, tmr, dend};
    return {1'b1, 1'b0, txe, rxf, tmr, dend, pwr, |(r & en)};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (tick %0d)", tag, act, exp, tk);
    end
  endtask

  task automatic step();
    @(negedge clk);
    stat_rd = 0; ctl_wr = 0; clr_wr = 0; tape_rd = 0; tape_wr = 0;
    rx_byte = 0; tx_need = 0;
  endtask

  task automatic wait_tk(input int n);
    while (tk < n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; tick_en = 0; stat_rd = 0; ctl_wr = 0; clr_wr = 0; tape_rd = 0;
    tape_wr = 0; rx_byte = 0; tx_need = 0; tx_mode = 0; ctl_data = 0; clr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 R2 R5: reset state
    chk("R5 reset status", stat_data, 8'h82);
    chk("R4 reset irq_n", {7'd0, irq_n}, 8'd1);
    // R3: ignored bits cannot force master or power-up
    ctl_wr = 1; ctl_data = 8'hC3; step();
    chk("R3 ignored write bits", stat_data, 8'h82);
    chk("R3 irq_n after ignored write", {7'd0, irq_n}, 8'd1);
    // R5: first read clears power-up
    stat_rd = 1; #1;
    chk("R5 read shows power-up", stat_data, 8'h82);
    step();
    chk("R5 power-up cleared", stat_data, 8'h80);
    ctl_wr = 1; ctl_data = 8'h02; step();
    chk("R3 bit1 write no effect", stat_data, 8'h80);

    tick_en = 1;
    // R4 R1: sweep of tape requests vs all enable masks
    for (int r = 0; r < 4; r++) begin
      for (int e = 0; e < 16; e++) begin
        tape_rd = 1; tape_wr = 1; step();
        rx_byte = r[0]; tx_need = r[1]; step();
        ctl_wr = 1; ctl_data = 8'(e << 2); step();
        chk("R4 sweep status", stat_data, exp_stat(0, 0, 0, r[0], r[1], 4'(e)));
        chk("R4 sweep irq_n", {7'd0, irq_n},
            {7'd0, ~|(4'(e) & {r[1], r[0], 2'b00})});
      end
    end
    // R9: set wins over clear
    tape_rd = 1; tape_wr = 1; step();
    rx_byte = 1; tape_rd = 1; step();
    chk("R9 rx set beats read", stat_data & 8'h30, 8'h10);
    tape_rd = 1; step();
    chk("R9 rx cleared by read", stat_data & 8'h30, 8'h00);
    // R10: write-mode entry, read does not clear, write clears
    tx_mode = 1; step();
    chk("R10 tx set on mode entry", stat_data & 8'h30, 8'h20);
    tape_rd = 1; step();
    chk("R10 read keeps tx", stat_data & 8'h30, 8'h20);
    tape_wr = 1; step();
    step();
    chk("R10 write clears tx, level no reset", stat_data & 8'h30, 8'h00);
    tx_mode = 0;
    ctl_wr = 1; ctl_data = 8'h0C; step();

    // R6: tick gap must not advance raster
    tick_en = 0; repeat (40) @(negedge clk); tick_en = 1;

    // R8: timer at end of line 100
    wait_tk(12927);
    chk("R8 timer before", stat_data, 8'h80);
    wait_tk(12928);
    chk("R8 timer after", stat_data, 8'h89);
    chk("R4 irq_n on timer", {7'd0, irq_n}, 8'd0);
    // R7: end of picture
    wait_tk(32767);
    chk("R7 dend before", stat_data & 8'h04, 8'h00);
    wait_tk(32768);
    chk("R7 dend after", stat_data, 8'h8D);
    // R11: selective clears
    clr_wr = 1; clr_data = 8'h04; step();
    chk("R11 clear dend only", stat_data, 8'h89);
    clr_wr = 1; clr_data = 8'hF3; step();
    chk("R11 other clear bits ignored", stat_data, 8'h89);
    clr_wr = 1; clr_data = 8'h08; step();
    chk("R11 clear timer", stat_data, 8'h80);
    chk("R4 irq_n released", {7'd0, irq_n}, 8'd1);
    // R6 R8 R11: next frame, event coincides with clear
    wait_tk(52863);
    chk("R6 no early repeat", stat_data, 8'h80);
    clr_wr = 1; clr_data = 8'h08; step();
    chk("R11 event beats clear (R8 repeat)", stat_data, 8'h89);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected<150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule